// File: doc/BRIEF.md
# Configuration Space Write/Erase Guard

This block decides, one request at a time, whether an access aimed at one of two configuration Flash spaces may proceed. Space A holds the device configuration. Space B holds the security and boot configuration. A request gives an operation kind, the target space and, for space B, the index of a 128-bit word. The guard weighs the operating mode, a set of configuration values captured while reset is held, and protect bits that software may set at run time. It answers with allow or deny one cycle later. It also raises erase strobes for each space that an allowed erase clears.

Protection of space B is armed only when a reset-captured 32-bit word matches an exact key value. Any other value leaves it disarmed. Every 128-bit word of space B that was already programmed when reset was taken cannot be programmed again until a page erase of space B. The space-A software protect bit is held in a persistent cell outside the block. The guard sets that cell's value through `a_wp_persist`, and the new setting takes effect only after the next reset, through `cfg_a_swp`. A chip erase always clears space A and its protections. It clears space B only when space B carries no protection.

Top module: `cfgspace_guard`

## Requirements
- R1: Operation codes are: 0 read, 1 CRC, 2 execute, 3 word program, 4 row program, 5 page erase, 6 chip erase, 7 reserved. Read and CRC are allowed for either space in every mode. Execute and the reserved code are always denied.
- R2: Row program (code 4) is denied for both spaces in every mode.
- R3: Modes are: 0 mission, 1 debug, 2 serial programming, 3 treated as mission. Outside serial programming, word program and page erase of space A (`op_space`=0) are denied under any of these conditions: the active software protect bit is set, the captured two-bit field `cfg_a_field` differs from the erased value 2'b11, code protection is active, or whole-Flash programming inhibit is active.
- R4: In serial programming mode, word program and page erase of space A are allowed even when the software bit or the field is set. They are still denied while code protection or the inhibit is active.
- R5: Space B write protection is armed from reset only when `cfg_b_wp_word` equals 32'h5B9B12E4. Erase protection is armed only when `cfg_b_ep_word` equals 32'h84C1F396. Any other value leaves that protection off.
- R6: While space B (`op_space`=1) is write protected, both word program and page erase are denied. Erase protection alone denies only page erase.
- R7: A chip erase is always allowed and pulses `erase_a`. It clears the space-A configuration field protection, code protection, the active software A bit and `a_wp_persist`. The inhibit is not cleared.
- R8: A chip erase pulses `erase_b`, and clears all space-B word tracking, only when space B has neither write nor erase protection.
- R9: A space-B word whose bit in `cfg_b_used` was 1 at reset is denied word program until an allowed space-B page erase. That erase pulses `erase_b` and clears the tracking of every word.
- R10: A pulse on `sw_set_b_wp` or `sw_set_b_ep` arms the matching space-B protection from the next request on. It stays set until reset.
- R11: A pulse on `sw_set_a_wp` sets `a_wp_persist` at once, but does not change space-A access until a reset captures it through `cfg_a_swp`.
- R12: A request sampled with `op_valid` gets `resp_valid` high for exactly one cycle on the next cycle. `erase_a` and `erase_b` pulse only together with an allowed erase response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration inputs are captured while low |
| op_valid | input | 1 | Request present this cycle |
| op_kind | input | 3 | Operation code (see R1) |
| op_space | input | 1 | 0 = space A, 1 = space B |
| op_word | input | IDX_W | 128-bit word index within space B |
| mode | input | 2 | Operating mode (see R3) |
| cfg_a_field | input | 2 | Space-A configuration protect field, 2'b11 = erased |
| cfg_a_swp | input | 1 | Persisted space-A software protect bit |
| cfg_code_prot | input | 1 | Code protection configured |
| cfg_inhibit | input | 1 | Whole-Flash programming inhibit configured |
| cfg_b_wp_word | input | 32 | Space-B write-protect key word |
| cfg_b_ep_word | input | 32 | Space-B erase-protect key word |
| cfg_b_used | input | B_WORDS | Per-word "already programmed" flags of space B |
| sw_set_a_wp | input | 1 | Software request to set space-A protect (after reset) |
| sw_set_b_wp | input | 1 | Software set of space-B write protect |
| sw_set_b_ep | input | 1 | Software set of space-B erase protect |
| resp_valid | output | 1 | Decision present |
| resp_allow | output | 1 | Decision: 1 = allowed |
| erase_a | output | 1 | Space A is erased by the answered request |
| erase_b | output | 1 | Space B is erased by the answered request |
| a_wp_persist | output | 1 | Value to keep in the persistent space-A protect cell |

## Verification
The assertions assume that the configuration inputs are meaningful only while reset is low. They also assume that a software set pulse never falls in the same cycle as a chip erase request. The checks rely on a decision always following a request by one cycle, whatever the other inputs are. The stimulus keeps to these assumptions. Software pulses and requests are issued in separate cycles. Configuration values change only inside a reset window. The key words are drawn either as the exact key, as a one-bit corruption of it, or at random.

// File: rtl/cfgspace_guard.sv
module cfgspace_guard #(
  parameter int          B_WORDS  = 8,
  parameter logic [31:0] B_WP_KEY = 32'h5B9B12E4,
  parameter logic [31:0] B_EP_KEY = 32'h84C1F396,
  localparam int         IDX_W    = (B_WORDS > 1) ? $clog2(B_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [2:0]         op_kind,
  input  logic               op_space,
  input  logic [IDX_W-1:0]   op_word,
  input  logic [1:0]         mode,
  input  logic [1:0]         cfg_a_field,
  input  logic               cfg_a_swp,
  input  logic               cfg_code_prot,
  input  logic               cfg_inhibit,
  input  logic [31:0]        cfg_b_wp_word,
  input  logic [31:0]        cfg_b_ep_word,
  input  logic [B_WORDS-1:0] cfg_b_used,
  input  logic               sw_set_a_wp,
  input  logic               sw_set_b_wp,
  input  logic               sw_set_b_ep,
  output logic               resp_valid,
  output logic               resp_allow,
  output logic               erase_a,
  output logic               erase_b,
  output logic               a_wp_persist
);

  localparam logic [2:0] K_READ = 3'd0;
  localparam logic [2:0] K_CRC  = 3'd1;
  localparam logic [2:0] K_EXEC = 3'd2;
  localparam logic [2:0] K_WORD = 3'd3;
  localparam logic [2:0] K_ROW  = 3'd4;
  localparam logic [2:0] K_PAGE = 3'd5;
  localparam logic [2:0] K_CHIP = 3'd6;

  logic               a_cfg, code_p, inhib, a_sw, a_pend;
  logic               b_wp_k, b_ep_k, b_wp_s, b_ep_s;
  logic [B_WORDS-1:0] used;
  logic               rv_q, al_q, ea_q, eb_q;

  logic serial, a_lock, b_wp, b_ep, word_ok, word_used, allow_c;
  logic do_chip, chip_b, page_a, page_b;

  assign serial    = (mode == 2'd2);
  assign a_lock    = code_p | inhib | (~serial & (a_sw | a_cfg));
  assign b_wp      = b_wp_k | b_wp_s;
  assign b_ep      = b_ep_k | b_ep_s;
  assign word_ok   = int'(op_word) < B_WORDS;
  assign word_used = word_ok ? used[op_word] : 1'b1;

  always_comb begin
    case (op_kind)
      K_READ, K_CRC: allow_c = 1'b1;
      K_WORD:        allow_c = op_space ? (~b_wp & ~word_used) : ~a_lock;
      K_PAGE:        allow_c = op_space ? (~b_wp & ~b_ep) : ~a_lock;
      K_CHIP:        allow_c = 1'b1;
      default:       allow_c = 1'b0;
    endcase
  end

  assign do_chip = op_valid & (op_kind == K_CHIP);
  assign chip_b  = ~b_wp & ~b_ep;
  assign page_a  = op_valid & (op_kind == K_PAGE) & ~op_space & allow_c;
  assign page_b  = op_valid & (op_kind == K_PAGE) &  op_space & allow_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_cfg  <= (cfg_a_field != 2'b11);
      code_p <= cfg_code_prot;
      inhib  <= cfg_inhibit;
      a_sw   <= cfg_a_swp;
      a_pend <= cfg_a_swp;
      b_wp_k <= (cfg_b_wp_word == B_WP_KEY);
      b_ep_k <= (cfg_b_ep_word == B_EP_KEY);
      b_wp_s <= 1'b0;
      b_ep_s <= 1'b0;
      used   <= cfg_b_used;
      rv_q   <= 1'b0;
      al_q   <= 1'b0;
      ea_q   <= 1'b0;
      eb_q   <= 1'b0;
    end else begin
      rv_q <= op_valid;
      al_q <= op_valid & allow_c;
      ea_q <= do_chip | page_a;
      eb_q <= (do_chip & chip_b) | page_b;
      if (do_chip) begin
        a_cfg  <= 1'b0;
        code_p <= 1'b0;
        a_sw   <= 1'b0;
        a_pend <= 1'b0;
      end else if (sw_set_a_wp) begin
        a_pend <= 1'b1;
      end
      if (sw_set_b_wp) b_wp_s <= 1'b1;
      if (sw_set_b_ep) b_ep_s <= 1'b1;
      if ((do_chip & chip_b) | page_b) used <= '0;
    end
  end

  assign resp_valid   = rv_q;
  assign resp_allow   = al_q;
  assign erase_a      = ea_q;
  assign erase_b      = eb_q;
  assign a_wp_persist = a_pend;

endmodule

module cfgspace_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [2:0] op_kind,
  input logic       op_space,
  input logic       sw_set_a_wp,
  input logic       b_wp,
  input logic       b_ep,
  input logic       resp_valid,
  input logic       resp_allow,
  input logic       erase_a,
  input logic       erase_b,
  input logic       a_wp_persist
);

  p_read_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_kind == 3'd0 || op_kind == 3'd1) |=> resp_valid && resp_allow);

  p_exec_deny_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_kind == 3'd2 || op_kind == 3'd7) |=> resp_valid && !resp_allow);

  p_row_deny_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == 3'd4 |=> !resp_allow);

  p_bwp_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_space && b_wp && (op_kind == 3'd3 || op_kind == 3'd5) |=> !resp_allow);

  p_bep_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_space && b_ep && op_kind == 3'd5 |=> !resp_allow && !erase_b);

  p_chip_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == 3'd6 |=> erase_a && resp_allow && !a_wp_persist);

  p_chip_b_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == 3'd6 && (b_wp || b_ep) |=> !erase_b);

  p_persist_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_wp_persist) |-> $past(sw_set_a_wp));

  p_resp_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> resp_valid);

  p_resp_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !resp_valid);

  p_erase_allowed_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_a || erase_b) |-> resp_valid && resp_allow);

endmodule

bind cfgspace_guard cfgspace_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
  .op_space(op_space), .sw_set_a_wp(sw_set_a_wp), .b_wp(b_wp), .b_ep(b_ep),
  .resp_valid(resp_valid), .resp_allow(resp_allow), .erase_a(erase_a),
  .erase_b(erase_b), .a_wp_persist(a_wp_persist)
);

// File: tb/cfgspace_guard_test.sv
`timescale 1ns/1ps
module cfgspace_guard_test;
  localparam int NW = 8;
  localparam logic [31:0] WPK = 32'h5B9B12E4;
  localparam logic [31:0] EPK = 32'h84C1F396;

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, op_space = 0;
  logic [2:0] op_kind = 0;
  logic [2:0] op_word = 0;
  logic [1:0] mode = 0, cfg_a_field = 2'b11;
  logic cfg_a_swp = 0, cfg_code_prot = 0, cfg_inhibit = 0;
  logic [31:0] cfg_b_wp_word = 0, cfg_b_ep_word = 0;
  logic [NW-1:0] cfg_b_used = 0;
  logic sw_set_a_wp = 0, sw_set_b_wp = 0, sw_set_b_ep = 0;
  logic resp_valid, resp_allow, erase_a, erase_b, a_wp_persist;

  int checks = 0, errors = 0;
  bit m_acfg, m_code, m_inh, m_asw, m_apend, m_bwpk, m_bepk, m_bwps, m_beps;
  bit [NW-1:0] m_used;

  cfgspace_guard #(.B_WORDS(NW)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_space(op_space), .op_word(op_word), .mode(mode),
    .cfg_a_field(cfg_a_field), .cfg_a_swp(cfg_a_swp),
    .cfg_code_prot(cfg_code_prot), .cfg_inhibit(cfg_inhibit),
    .cfg_b_wp_word(cfg_b_wp_word), .cfg_b_ep_word(cfg_b_ep_word),
    .cfg_b_used(cfg_b_used), .sw_set_a_wp(sw_set_a_wp),
    .sw_set_b_wp(sw_set_b_wp), .sw_set_b_ep(sw_set_b_ep),
    .resp_valid(resp_valid), .resp_allow(resp_allow), .erase_a(erase_a),
    .erase_b(erase_b), .a_wp_persist(a_wp_persist));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_bwp(); return m_bwpk | m_bwps; endfunction
  function automatic bit m_bep(); return m_bepk | m_beps; endfunction

  function automatic bit exp_allow(input logic [2:0] k, input logic sp,
                                   input logic [2:0] w, input logic [1:0] md);
    bit lock_a;
    lock_a = m_code | m_inh | ((md != 2'd2) & (m_asw | m_acfg));
    case (k)
      3'd0, 3'd1, 3'd6: return 1'b1;
      3'd3: return sp ? (!m_bwp() && !m_used[w]) : !lock_a;
      3'd5: return sp ? (!m_bwp() && !m_bep()) : !lock_a;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] k, input logic sp);
    case (k)
      3'd0, 3'd1, 3'd2, 3'd7: return "R1";
      3'd4: return "R2";
      3'd6: return "R7";
      default: return sp ? "R6" : "R3";
    endcase
  endfunction

  task automatic do_op(input logic [2:0] k, input logic sp, input logic [2:0] w,
                       input logic [1:0] md, input string req);
    bit ea, eb, al;
    @(negedge clk);
    op_valid = 1; op_kind = k; op_space = sp; op_word = w; mode = md;
    al = exp_allow(k, sp, w, md);
    ea = (k == 3'd6) || (k == 3'd5 && !sp && al);
    eb = (k == 3'd6 && !m_bwp() && !m_bep()) || (k == 3'd5 && sp && al);
    @(negedge clk);
    op_valid = 0;
    chk({req, " valid"}, resp_valid, 1);
    chk({req, " allow"}, resp_allow, al);
    chk({req, " erase_a"}, erase_a, ea);
    chk({req, " erase_b"}, erase_b, eb);
    if (k == 3'd6) begin
      m_acfg = 0; m_code = 0; m_asw = 0; m_apend = 0;
    end
    if (eb) m_used = '0;
  endtask

  task automatic sw_pulse(input int which);
    @(negedge clk);
    if (which == 0) sw_set_a_wp = 1;
    if (which == 1) sw_set_b_wp = 1;
    if (which == 2) sw_set_b_ep = 1;
    @(negedge clk);
    sw_set_a_wp = 0; sw_set_b_wp = 0; sw_set_b_ep = 0;
    if (which == 0) m_apend = 1;
    if (which == 1) m_bwps = 1;
    if (which == 2) m_beps = 1;
  endtask

  task automatic do_reset(input logic [1:0] fld, input logic swp, input logic cp,
                          input logic inh, input logic [31:0] wpw,
                          input logic [31:0] epw, input logic [NW-1:0] usd);
    @(negedge clk);
    rst_n = 0; cfg_a_field = fld; cfg_a_swp = swp; cfg_code_prot = cp;
    cfg_inhibit = inh; cfg_b_wp_word = wpw; cfg_b_ep_word = epw; cfg_b_used = usd;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_acfg = (fld != 2'b11); m_code = cp; m_inh = inh; m_asw = swp; m_apend = swp;
    m_bwpk = (wpw == WPK); m_bepk = (epw == EPK); m_bwps = 0; m_beps = 0;
    m_used = usd;
    @(negedge clk);
    chk("R12 idle valid", resp_valid, 0);
    chk("R12 idle erase", {erase_a, erase_b}, 0);
    chk("R11 persist at reset", a_wp_persist, swp);
  endtask

  function automatic logic [31:0] pick_key(input logic [31:0] key);
    int r;
    r = $urandom_range(0, 2);
    if (r == 0) return key;
    if (r == 1) return key ^ (32'd1 << $urandom_range(0, 31));
    return $urandom();
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(2'b11, 0, 0, 0, 0, 0, '0);
    do_op(3'd0, 0, 0, 2'd0, "R1 read A");
    do_op(3'd1, 1, 0, 2'd1, "R1 crc B");
    do_op(3'd2, 0, 0, 2'd2, "R1 exec A");
    do_op(3'd2, 1, 0, 2'd0, "R1 exec B");
    do_op(3'd7, 1, 0, 2'd0, "R1 reserved");
    do_op(3'd4, 0, 0, 2'd2, "R2 row A");
    do_op(3'd4, 1, 0, 2'd2, "R2 row B");
    do_op(3'd3, 0, 0, 2'd0, "R3 A free");
    // R3 / R4: field armed
    do_reset(2'b10, 0, 0, 0, 0, 0, '0);
    do_op(3'd3, 0, 0, 2'd0, "R3 A field mission");
    do_op(3'd5, 0, 0, 2'd1, "R3 A field debug");
    do_op(3'd3, 0, 0, 2'd2, "R4 A field serial");
    do_op(3'd5, 0, 0, 2'd2, "R4 A erase serial");
    do_reset(2'b11, 0, 1, 0, 0, 0, '0);
    do_op(3'd3, 0, 0, 2'd2, "R4 code prot serial");
    do_op(3'd6, 0, 0, 2'd0, "R7 chip clears code");
    do_op(3'd3, 0, 0, 2'd0, "R7 A after chip");
    do_reset(2'b11, 0, 0, 1, 0, 0, '0);
    do_op(3'd5, 0, 0, 2'd2, "R4 inhibit serial");
    do_op(3'd6, 0, 0, 2'd2, "R7 chip");
    do_op(3'd3, 0, 0, 2'd2, "R7 inhibit kept");
    // R5 / R6 / R8
    do_reset(2'b11, 0, 0, 0, WPK, 0, '0);
    do_op(3'd3, 1, 1, 2'd2, "R5 wp key prog");
    do_op(3'd6, 0, 0, 2'd0, "R8 chip with wp");
    do_reset(2'b11, 0, 0, 0, WPK ^ 32'h1, EPK, '0);
    do_op(3'd3, 1, 1, 2'd0, "R5 near key wp off");
    do_op(3'd5, 1, 0, 2'd0, "R6 ep blocks erase");
    do_op(3'd6, 0, 0, 2'd0, "R8 chip with ep");
    do_reset(2'b11, 0, 0, 0, 0, EPK ^ 32'h80000000, 8'h0F);
    do_op(3'd3, 1, 2, 2'd0, "R9 used word");
    do_op(3'd3, 1, 5, 2'd0, "R9 unused word");
    do_op(3'd5, 1, 0, 2'd0, "R5 near key ep off");
    do_op(3'd3, 1, 2, 2'd0, "R9 after page erase");
    // R10
    do_reset(2'b11, 0, 0, 0, 0, 0, 8'h01);
    sw_pulse(2);
    do_op(3'd5, 1, 0, 2'd0, "R10 sw ep");
    do_op(3'd3, 1, 3, 2'd0, "R10 ep allows prog");
    sw_pulse(1);
    do_op(3'd3, 1, 3, 2'd0, "R10 sw wp");
    do_op(3'd6, 0, 0, 2'd0, "R8 chip with sw prot");
    do_op(3'd3, 1, 0, 2'd0, "R9 tracking kept");
    // R11
    do_reset(2'b11, 0, 0, 0, 0, 0, '0);
    sw_pulse(0);
    chk("R11 persist set", a_wp_persist, 1);
    do_op(3'd3, 0, 0, 2'd0, "R11 not yet active");
    do_reset(2'b11, a_wp_persist, 0, 0, 0, 0, '0);
    do_op(3'd3, 0, 0, 2'd0, "R11 active after reset");
    do_op(3'd3, 0, 0, 2'd2, "R4 sw bit serial");
    do_op(3'd6, 0, 0, 2'd0, "R7 chip clears sw");
    chk("R7 persist cleared", a_wp_persist, 0);
    do_op(3'd3, 0, 0, 2'd0, "R7 A writable");
    // random
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 19);
      if (r == 0)
        do_reset(2'($urandom), ($urandom_range(0, 1) == 0) ? a_wp_persist : 1'($urandom),
                 ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                 pick_key(WPK), pick_key(EPK), NW'($urandom));
      else if (r == 1)
        sw_pulse($urandom_range(0, 2));
      else begin
        logic [2:0] k;
        logic sp;
        k = 3'($urandom);
        if (k == 3'd6 && $urandom_range(0, 2) != 0) k = 3'd3;
        sp = 1'($urandom);
        do_op(k, sp, 3'($urandom), 2'($urandom), tag(k, sp));
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule